// File: doc/BRIEF.md
# Phase-Accumulator PWM Channel with Cycle-Aligned Setting Update

This block generates one pulse-width modulated output. A phase accumulator adds a programmable increment on every clock. The output period ends each time the accumulator carries out of its top bit, so the output frequency is increment × f_clk / 2^BU_W. The duty cycle comes from an inverted 8-bit threshold that is compared against the top byte of the accumulator.

Software controls the channel through one 32-bit register, with a write strobe and a read-data bus. New settings first land in a shadow copy. They reach the live datapath only when software raises the update flag. The hardware then moves them into the active copy at the next period boundary and clears the flag by itself. While the flag is set, the register ignores every write, so a pending update cannot be torn. The register port is plain control with no handshake: a write takes effect at the clock edge where the strobe is high, and read data is combinational from the register state.

Top module: `pwm_acc_chan`

## Requirements
- R1: After reset, the enable bit, the update flag, the shadow and active settings and the accumulator are all zero. `rd_data` reads 0 and `pwm_out` is low.
- R2: The register has this layout: bit 31 is enable, bit 30 is the update flag, bits [8 +: BU_W] hold the increment, and bits [7:0] hold the duty threshold. A read returns the enable bit, the live flag and the shadow settings. All other bits read as zero, even when they were written as one.
- R3: A write that arrives while the update flag reads 1 changes nothing in the register: not the enable bit, not the flag, not the shadow settings.
- R4: With the channel enabled and a non-zero active increment, a raised flag holds until the clock edge where the accumulator carries out. At that edge the shadow increment and threshold become active and the flag clears. Until then, the old settings still drive the output.
- R5: While enabled, the accumulator grows by the active increment on every clock and wraps modulo 2^BU_W. When the increment divides 2^BU_W, the output repeats every 2^BU_W / increment clocks.
- R6: While enabled, `pwm_out` is high exactly when the accumulator's top 8 bits are strictly greater than the active threshold. A threshold of 0 keeps the output high in every clock except those where the top byte is 0. A threshold of 255 keeps it always low.
- R7: While enable is 0, `pwm_out` is low and the accumulator is cleared, so a later enable starts from phase zero. A raised flag is applied and cleared on the next clock edge.
- R8: While the active increment is 0, the accumulator holds its value and the output keeps a static level. A raised flag is applied and cleared on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, sampled on the rising clock edge |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data: enable, live update flag, shadow settings |
| pwm_out | output | 1 | Modulated output |

## Verification
Two things can land on the same clock edge: the accumulator's carry-out, which both ends a period and moves the shadow into the active copy, and a write by software. The bench raises the flag mid-period and then writes fresh settings while the flag is still up. It checks that the read-back keeps the first settings and that the old threshold still shapes the output up to the carry. It then checks that the flag drops, and the new threshold takes over, on exactly that carry edge. A second case makes the carry-edge update itself load a zero increment, and the output must then freeze.

// File: rtl/pwm_acc_pkg.sv
package pwm_acc_pkg;
  localparam int REG_W    = 32;
  localparam int EN_POS   = 31;
  localparam int UPD_POS  = 30;
  localparam int INC_LSB  = 8;
  localparam int THR_W    = 8;
  localparam int MAX_INCW = UPD_POS - INC_LSB;
endpackage

// File: rtl/pwm_acc_regs.sv
module pwm_acc_regs
  import pwm_acc_pkg::*;
#(
  parameter int BU_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wrap,
  output logic             en,
  output logic             upd,
  output logic [BU_W-1:0]  act_inc,
  output logic [THR_W-1:0] act_thr,
  output logic [REG_W-1:0] rd_data
);
  logic             en_q, upd_q;
  logic [BU_W-1:0]  sh_inc;
  logic [THR_W-1:0] sh_thr;
  logic             accept, apply;

  assign accept = wr_en && !upd_q;
  assign apply  = upd_q && (!en_q || wrap || (act_inc == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      upd_q   <= 1'b0;
      sh_inc  <= '0;
      sh_thr  <= '0;
      act_inc <= '0;
      act_thr <= '0;
    end else begin
      if (accept) begin
        en_q   <= wr_data[EN_POS];
        upd_q  <= wr_data[UPD_POS];
        sh_inc <= wr_data[INC_LSB +: BU_W];
        sh_thr <= wr_data[THR_W-1:0];
      end else if (apply) begin
        upd_q   <= 1'b0;
        act_inc <= sh_inc;
        act_thr <= sh_thr;
      end
    end
  end

  always_comb begin
    rd_data                   = '0;
    rd_data[EN_POS]           = en_q;
    rd_data[UPD_POS]          = upd_q;
    rd_data[INC_LSB +: BU_W]  = sh_inc;
    rd_data[THR_W-1:0]        = sh_thr;
  end

  assign en  = en_q;
  assign upd = upd_q;

  // R3
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q && wr_en) |=> ($stable(sh_inc) && $stable(sh_thr) && $stable(en_q)));

  // R4
  flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(upd_q) |-> $past(!en_q || wrap || (act_inc == '0)));

  // R4
  active_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_inc != $past(act_inc) || act_thr != $past(act_thr)) |-> $past(upd_q));
endmodule

// File: rtl/pwm_acc_phase.sv
module pwm_acc_phase #(
  parameter int BU_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [BU_W-1:0] inc,
  output logic [BU_W-1:0] acc,
  output logic            wrap
);
  logic [BU_W:0] sum;

  assign sum  = {1'b0, acc} + {1'b0, inc};
  assign wrap = en && sum[BU_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (!en) acc <= '0;
    else          acc <= sum[BU_W-1:0];
  end

  // R7
  acc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (acc == '0));

  // R8
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && inc == '0) |=> $stable(acc));
endmodule

// File: rtl/pwm_acc_cmp.sv
module pwm_acc_cmp
  import pwm_acc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [THR_W-1:0] phase_top,
  input  logic [THR_W-1:0] thr,
  output logic             pwm
);
  assign pwm = en && (phase_top > thr);

  // R6
  thr_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == {THR_W{1'b1}}) |-> !pwm);

  // R7
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |=> !pwm);
endmodule

// File: rtl/pwm_acc_chan.sv
module pwm_acc_chan
  import pwm_acc_pkg::*;
#(
  parameter int BU_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        pwm_out
);
  localparam int TOP_LSB = BU_W - THR_W;

  generate
    if (!(BU_W == 16 || BU_W == 22) || BU_W > MAX_INCW) begin : g_bad_width
      $error("BU_W must be 16 or 22");
    end
  endgenerate

  logic             en, upd, wrap;
  logic [BU_W-1:0]  act_inc, acc;
  logic [THR_W-1:0] act_thr;

  pwm_acc_regs #(.BU_W(BU_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wrap(wrap), .en(en), .upd(upd), .act_inc(act_inc),
    .act_thr(act_thr), .rd_data(rd_data)
  );

  pwm_acc_phase #(.BU_W(BU_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(en), .inc(act_inc),
    .acc(acc), .wrap(wrap)
  );

  pwm_acc_cmp u_cmp (
    .clk(clk), .rst_n(rst_n), .en(en),
    .phase_top(acc[TOP_LSB +: THR_W]), .thr(act_thr), .pwm(pwm_out)
  );

  // R4
  upd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && en && act_inc != '0 && !wrap && !wr_en) |=> upd);
endmodule

// File: tb/pwm_acc_chan_bench.sv
`timescale 1ns/1ps
module pwm_acc_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_acc_chan u_pwm_acc_chan (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pwm_out(pwm_out)
  );

  // increment, threshold, highs in 64 samples, rising edges in 64 samples
  localparam int VEC [5][4] = '{
    '{4096, 128, 28, 4},
    '{4096,   0, 60, 4},
    '{4096, 255,  0, 0},
    '{8192, 112, 32, 8},
    '{2048, 128, 30, 2}
  };

  function automatic logic [31:0] word(bit e, bit u, int inc, int thr);
    return {e, u, 6'b0, inc[15:0], thr[7:0]};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi, rs;
    bit prev;
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 32'h0, "R1 rd", rd_data, 32'h0);
    chk(pwm_out == 1'b0, "R1 pwm", {31'b0, pwm_out}, 32'h0);

    wr(32'h3FAB_CD5A);
    chk(rd_data == 32'h00AB_CD5A, "R2 readback", rd_data, 32'h00AB_CD5A);

    // R8: zero active increment lets the pending flag apply at once
    wr(word(1, 1, 4096, 0));
    chk(rd_data[30] == 1'b1, "R8 flag set", rd_data, 32'hC010_0000);
    step(1);
    chk(rd_data == 32'h8010_0000, "R8 flag cleared", rd_data, 32'h8010_0000);
    step(1);
    chk(pwm_out == 1'b1, "R8 running", {31'b0, pwm_out}, 32'h1);

    // R7: disable clears phase; enable restarts from zero
    wr(word(0, 0, 4096, 0));
    chk(pwm_out == 1'b0, "R7 off low", {31'b0, pwm_out}, 32'h0);
    step(2);
    wr(word(1, 0, 4096, 0));
    chk(pwm_out == 1'b0, "R7 phase zero", {31'b0, pwm_out}, 32'h0);
    step(1);
    chk(pwm_out == 1'b1, "R7 phase step", {31'b0, pwm_out}, 32'h1);
    wr(word(0, 1, 8192, 128));
    chk(rd_data[30] == 1'b1, "R7 flag set", rd_data, 32'h4020_0080);
    step(1);
    chk(rd_data == 32'h0020_0080, "R7 flag applied", rd_data, 32'h0020_0080);

    // R5 / R6 table
    for (int v = 0; v < 5; v++) begin
      wr(word(0, 1, VEC[v][0], VEC[v][1]));
      step(1);
      chk(rd_data[30] == 1'b0, "R7 table flag", rd_data, 32'h0);
      wr(word(1, 0, VEC[v][0], VEC[v][1]));
      hi = 0; rs = 0; prev = 1'b0;
      for (int s = 0; s < 64; s++) begin
        if (pwm_out) hi++;
        if (pwm_out && !prev) rs++;
        prev = pwm_out;
        @(negedge clk);
      end
      chk(hi == VEC[v][2], "R6 duty highs", hi, VEC[v][2]);
      chk(rs == VEC[v][3], "R5 period edges", rs, VEC[v][3]);
    end

    // R4 / R3: deferred update lands on the carry edge
    wr(word(0, 1, 4096, 128));
    step(1);
    wr(word(1, 0, 4096, 128));          // phase 0 after this edge
    wr(word(1, 1, 8192, 0));            // phase 4096, flag up
    chk(rd_data == 32'hC020_0000, "R4 flag up", rd_data, 32'hC020_0000);
    chk(pwm_out == 1'b0, "R4 old thr", {31'b0, pwm_out}, 32'h0);
    wr(word(0, 0, 16'h1111, 8'h22));    // ignored, phase 8192
    chk(rd_data == 32'hC020_0000, "R3 write ignored", rd_data, 32'hC020_0000);
    step(13);                           // phase 61440
    chk(rd_data[30] == 1'b1, "R4 flag held", rd_data, 32'hC020_0000);
    chk(pwm_out == 1'b1, "R3 still enabled", {31'b0, pwm_out}, 32'h1);
    step(1);                            // carry edge
    chk(rd_data == 32'h8020_0000, "R4 flag drop", rd_data, 32'h8020_0000);
    chk(pwm_out == 1'b0, "R4 phase zero", {31'b0, pwm_out}, 32'h0);
    step(1);
    chk(pwm_out == 1'b1, "R4 new thr", {31'b0, pwm_out}, 32'h1);

    // R8: update to zero increment freezes the phase at the carry
    wr(word(1, 1, 0, 0));
    step(40);
    chk(rd_data == 32'h8000_0000, "R8 zero applied", rd_data, 32'h8000_0000);
    hi = 0;
    for (int s = 0; s < 20; s++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
    chk(hi == 0, "R8 frozen", hi, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule